// File: doc/BRIEF.md
# Global-History XOR Branch Direction Predictor

This block guesses, at fetch time, whether a branch or jump will be taken. It forms a table index by XORing the word address bits of the fetch PC with a register that holds the outcomes of recent branches. The index selects one entry in a table of two-bit saturating counters. The prediction is the upper bit of the selected counter. The lookup is combinational, and the index it used is returned next to the prediction so that the pipeline can carry it along with the instruction.

When the branch resolves in the execute stage, the pipeline presents the carried index and the real outcome on the update port. On that clock edge the selected counter is trained and the outcome is shifted into the history register. Target prediction and flush control are handled by other blocks.

Top module: `gshare_dir`

## Requirements
- R1: `lk_idx` equals `lk_pc[9:2]` XOR the 8-bit history register, combinationally, in the same cycle as the lookup.
- R2: `lk_taken` is 1 when the counter at `lk_idx` holds 2 or 3, and 0 when it holds 0 or 1.
- R3: After reset, the history register is 0 and every one of the 256 counters holds 1 (weakly not taken), so every lookup predicts not taken.
- R4: A valid update with `up_taken`=1 increments the counter at `up_idx` by one on the next clock edge, saturating at 3.
- R5: A valid update with `up_taken`=0 decrements the counter at `up_idx` by one on the next clock edge, saturating at 0.
- R6: A valid update shifts the history register left by one bit and places `up_taken` in bit 0, visible from the next cycle.
- R7: Training uses only the carried `up_idx` and does not recompute an index from the current PC or history.
- R8: While `up_valid` is 0, neither the counters nor the history change, whatever `up_taken` and `up_idx` hold.
- R9: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction of the counter value before the update.
- R10: PC bits outside [9:2] have no effect on `lk_idx` or `lk_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch address being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | 8 | Table index used for this lookup |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_idx | input | 8 | Index carried from the lookup of this branch |

## Verification
The bench drives a counter up past 3 and down past 0 and then reverses direction once. A counter that wraps instead of saturating flips its prediction too early or too late. It also updates an entry while the history has moved since the lookup. A design that recomputes the index would train the wrong entry. Cycles with `up_valid` low carry changing data on `up_taken` and `up_idx`, which would expose a leaky enable through the history seen in `lk_idx`. Same-entry lookup and update cycles catch a lookup that bypasses the new value. Random PC upper bits catch a wrong bit slice.

// File: rtl/gshare_dir.sv
module gshare_dir #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_idx,
  input  logic              up_valid,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_idx
);
  localparam int ENTRIES = 1 << HIST_W;

  logic [HIST_W-1:0] hist;
  logic [1:0]        tbl [ENTRIES];
  logic [1:0]        cur;

  assign lk_idx   = lk_pc[PC_LSB +: HIST_W] ^ hist;
  assign lk_taken = tbl[lk_idx][1];
  assign cur      = tbl[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 2'd1;
    end else if (up_valid) begin
      hist <= {hist[HIST_W-2:0], up_taken};
      if (up_taken && cur != 2'd3)
        tbl[up_idx] <= cur + 2'd1;
      else if (!up_taken && cur != 2'd0)
        tbl[up_idx] <= cur - 2'd1;
    end
  end

  // R8
  upv_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(up_valid));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));

  // R8
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> tbl[$past(up_idx)] == $past(cur));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist[0] == $past(up_taken));

  // R4
  ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && cur == 2'd3) |=> tbl[$past(up_idx)] == 2'd3);

  // R5
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && cur == 2'd0) |=> tbl[$past(up_idx)] == 2'd0);
endmodule

// File: tb/sim_gshare_dir.sv
module sim_gshare_dir;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [7:0]  lk_idx;
  logic        up_valid = 0;
  logic        up_taken = 0;
  logic [7:0]  up_idx = '0;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_tbl [256];
  logic [7:0] m_hist;

  always #5 clk = ~clk;

  gshare_dir u0 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
                 .lk_idx(lk_idx), .up_valid(up_valid), .up_taken(up_taken), .up_idx(up_idx));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_for(input logic [7:0] idx, input logic [21:0] hi);
    return {hi, idx ^ m_hist, 2'b00};
  endfunction

  function automatic logic [1:0] train(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic step(input logic [31:0] pc, input logic v, input logic t,
                      input logic [7:0] ui, input string tag);
    logic [7:0] ei;
    @(negedge clk);
    lk_pc = pc; up_valid = v; up_taken = t; up_idx = ui;
    #1;
    ei = pc[9:2] ^ m_hist;
    chk({tag, " R1 R10 idx"}, int'(lk_idx), int'(ei));
    chk({tag, " R2 R9 pred"}, int'(lk_taken), int'(m_tbl[ei][1]));
    @(posedge clk);
    if (v) begin
      m_tbl[ui] = train(m_tbl[ui], t);
      m_hist = {m_hist[6:0], t};
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a;
    logic [7:0] q [$];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_tbl[i] = 2'd1;
    m_hist = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R3: reset state seen through lookups
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      lk_pc = $urandom; up_valid = 0; #1;
      chk("R3 idx", int'(lk_idx), int'(lk_pc[9:2]));
      chk("R3 pred", int'(lk_taken), 0);
    end

    // R4: climb to ceiling, one step down stays taken
    for (int i = 0; i < 5; i++) step(pc_for(8'd5, 22'($urandom)), 1, 1, 8'd5, "R4 up");
    step(pc_for(8'd5, 22'd0), 1, 0, 8'd5, "R4 down1");
    step(pc_for(8'd5, 22'd0), 0, 0, 8'd0, "R4 ceil");
    chk("R4 ceil pred", int'(lk_taken), 1);

    // R5: fall to floor, one step up stays not taken
    for (int i = 0; i < 5; i++) step(pc_for(8'd5, 22'($urandom)), 1, 0, 8'd5, "R5 dn");
    step(pc_for(8'd5, 22'd0), 1, 1, 8'd5, "R5 up1");
    step(pc_for(8'd5, 22'd0), 0, 0, 8'd0, "R5 floor");
    chk("R5 floor pred", int'(lk_taken), 0);

    // R6: history shift pattern via pc=0 lookup
    for (int i = 0; i < 10; i++) step(32'd0, 1, (i % 3) == 0, 8'(i + 40), "R6 hist");
    step(32'd0, 0, 0, 8'd0, "R6 view");
    chk("R6 hist", int'(lk_idx), int'(m_hist));

    // R8: invalid updates with busy data change nothing
    a = m_hist;
    for (int i = 0; i < 20; i++) step(32'($urandom), 0, 1'($urandom), 8'($urandom), "R8 idle");
    step(32'd0, 0, 1, 8'hff, "R8 view");
    chk("R8 hist held", int'(lk_idx), int'(a));

    // R7: train carried index after history moved
    step(pc_for(8'd77, 22'd3), 0, 0, 8'd0, "R7 look");
    a = 8'd77;
    step(32'd0, 1, 1, 8'd200, "R7 move");
    step(32'd0, 1, 1, 8'd201, "R7 move");
    step(pc_for(8'd9, 22'd0), 1, 1, a, "R7 train1");
    step(pc_for(8'd9, 22'd0), 1, 1, a, "R7 train2");
    step(pc_for(a, 22'd0), 0, 0, 8'd0, "R7 view");
    chk("R7 carried idx pred", int'(lk_taken), 1);

    // R9: same-entry lookup and update
    step(pc_for(8'd120, 22'd0), 1, 1, 8'd120, "R9 same1");
    step(pc_for(8'd120, 22'd0), 1, 1, 8'd120, "R9 same2");
    step(pc_for(8'd120, 22'd0), 1, 0, 8'd120, "R9 same3");

    // random mix with carried indices
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc;
      logic [7:0]  ui;
      logic        v;
      pc = ($urandom % 4 == 0) ? {22'($urandom), 10'($urandom % 64) << 2} : $urandom;
      v  = ($urandom % 10) < 7;
      ui = (q.size() > 2 && v) ? q.pop_front() : 8'($urandom);
      q.push_back(pc[9:2] ^ m_hist);
      step(pc, v, 1'($urandom), ui, "RND");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule